// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. It takes two 4-bit operands and a 3-bit condition code, and drives a single branch-taken bit. Six conditions are supported: equality, inequality, and less-than or greater-or-equal under both signed (two's complement) and unsigned interpretation. The two reserved codes force the result low.

The block has no clock and no state. Both operands share one packed 8-bit input bus. The condition code arrives on the low three lines of a bidirectional pin group, and that group is held in input mode. The result is valid in the same cycle the inputs change. A decode stage or execute stage places it beside its arithmetic unit and reads the taken bit directly.

Top module: `branch_cond_eval`

## Requirements
- R1: Operand A is `pin_in[7:4]`, operand B is `pin_in[3:0]`, and the branch-taken result is `pin_out[0]`.
- R2: Code 0 (equal) gives 1 exactly when A equals B. For example, A=5 and B=5 give 1.
- R3: Code 1 (not equal) gives 1 exactly when A differs from B.
- R4: Code 2 (signed less-than) and code 3 (signed greater-or-equal) read both operands as 4-bit two's complement. For example, 0x8 is -8 and is less than 0x7, and A=3, B=5 under code 2 gives 1.
- R5: Code 4 (unsigned less-than) and code 5 (unsigned greater-or-equal) compare magnitudes 0 to 15. For example, A=3, B=5 under code 4 gives 1, and A=5, B=3 under code 5 gives 1.
- R6: When the operands' top bits differ, the signed and unsigned less-than results are opposite. For example, A=0xF and B=0x1 give 1 under code 2 and 0 under code 4.
- R7: Codes 6 and 7 are reserved and drive `pin_out[0]` to 0 for every operand pair.
- R8: `pin_out[7:1]`, all of `pio_out` and all of `pio_oe` are always 0.
- R9: The result is combinational. A new input value is reflected on `pin_out[0]` before any clock edge, and no earlier input affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pin_in | input | 8 | Packed operands: A in bits 7..4, B in bits 3..0 |
| pio_in | input | 3 | Condition code from the bidirectional pins in input mode |
| pin_out | output | 8 | Bit 0 is branch-taken; the other bits are 0 |
| pio_out | output | 8 | Bidirectional output values, all 0 |
| pio_oe | output | 8 | Bidirectional output enables, all 0 (input mode) |

## Verification
The embedded checks assume every input bit is a known 0 or 1 whenever they are evaluated. They also assume the condition code takes one of its eight 3-bit values. Because the block has no state, no reset window is needed. The bench applies only fully defined values, one stimulus per cycle. It changes inputs just after a rising edge and reads the outputs at the falling edge. It sweeps every operand pair under every code, so the reserved codes and the sign-boundary pairs are covered by construction.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    C_EQ   = 3'd0,
    C_NE   = 3'd1,
    C_SLT  = 3'd2,
    C_SGE  = 3'd3,
    C_ULT  = 3'd4,
    C_UGE  = 3'd5,
    C_RSV6 = 3'd6,
    C_RSV7 = 3'd7
  } cond_e;

  typedef struct packed {
    logic eq;
    logic slt;
    logic ult;
  } cmp_flags_t;

endpackage

// File: rtl/bce_unpack.sv
module bce_unpack #(
  parameter int unsigned OPD_W = 4,
  localparam int unsigned BUS_W = 2 * OPD_W
) (
  input  logic [BUS_W-1:0] bus,
  output logic [OPD_W-1:0] opd_a,
  output logic [OPD_W-1:0] opd_b
);

  localparam int unsigned B_LO = 0;
  localparam int unsigned A_LO = OPD_W;

  // R1: A occupies the upper half of the bus, B the lower half
  assign opd_a = bus[A_LO +: OPD_W];
  assign opd_b = bus[B_LO +: OPD_W];

endmodule

// File: rtl/bce_compare.sv
module bce_compare
  import bce_pkg::*;
#(
  parameter int unsigned OPD_W = 4
) (
  input  logic [OPD_W-1:0] opd_a,
  input  logic [OPD_W-1:0] opd_b,
  output cmp_flags_t       flags
);

  localparam int unsigned MSB = OPD_W - 1;

  function automatic logic f_same(input logic [OPD_W-1:0] x, input logic [OPD_W-1:0] y);
    return x == y;
  endfunction

  function automatic logic f_less_signed(input logic [OPD_W-1:0] x, input logic [OPD_W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  function automatic logic f_less_mag(input logic [OPD_W-1:0] x, input logic [OPD_W-1:0] y);
    return x < y;
  endfunction

  logic eq_w, slt_w, ult_w, signs_split;

  assign eq_w        = f_same(opd_a, opd_b);
  assign slt_w       = f_less_signed(opd_a, opd_b);
  assign ult_w       = f_less_mag(opd_a, opd_b);
  assign signs_split = opd_a[MSB] ^ opd_b[MSB];

  assign flags = '{eq: eq_w, slt: slt_w, ult: ult_w};

  always_comb begin
    AST_EQ_NOT_LESS: assert (!eq_w || (!slt_w && !ult_w)); // R2
    AST_SIGN_SPLIT_FLIPS: assert (!signs_split || (slt_w != ult_w)); // R6
    AST_SAME_SIGN_AGREE: assert (signs_split || (slt_w == ult_w)); // R4
  end

endmodule

// File: rtl/bce_select.sv
module bce_select
  import bce_pkg::*;
(
  input  cond_e      sel,
  input  cmp_flags_t flags,
  output logic       taken
);

  logic is_reserved;
  assign is_reserved = (sel == C_RSV6) || (sel == C_RSV7);

  always_comb begin
    case (sel)
      C_EQ:    taken = flags.eq;
      C_NE:    taken = !flags.eq;
      C_SLT:   taken = flags.slt;
      C_SGE:   taken = !flags.slt;
      C_ULT:   taken = flags.ult;
      C_UGE:   taken = !flags.ult;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    AST_RESERVED_QUIET: assert (!is_reserved || !taken); // R7
    AST_EQ_VS_LESS: assert (!((sel == C_SLT || sel == C_ULT) && flags.eq) || !taken); // R2
    AST_GE_WHEN_EQUAL: assert (!((sel == C_SGE || sel == C_UGE) && flags.eq) || taken); // R5
  end

endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int unsigned OPD_W = 4,
  localparam int unsigned BUS_W = 2 * OPD_W
) (
  input  logic [BUS_W-1:0] pin_in,
  input  logic [SEL_W-1:0] pio_in,
  output logic [BUS_W-1:0] pin_out,
  output logic [BUS_W-1:0] pio_out,
  output logic [BUS_W-1:0] pio_oe
);

  logic [OPD_W-1:0] opd_a, opd_b;
  cmp_flags_t       flags;
  logic             taken;

  bce_unpack #(.OPD_W(OPD_W)) u_unpack (
    .bus   (pin_in),
    .opd_a (opd_a),
    .opd_b (opd_b)
  );

  bce_compare #(.OPD_W(OPD_W)) u_compare (
    .opd_a (opd_a),
    .opd_b (opd_b),
    .flags (flags)
  );

  bce_select u_select (
    .sel   (cond_e'(pio_in)),
    .flags (flags),
    .taken (taken)
  );

  // R8: only bit 0 carries data; the bidirectional group stays in input mode
  assign pin_out = {{(BUS_W-1){1'b0}}, taken};
  assign pio_out = '0;
  assign pio_oe  = '0;

  always_comb begin
    AST_UPPER_PINS_LOW: assert (pin_out[BUS_W-1:1] == '0 && pio_oe == '0 && pio_out == '0); // R8
    AST_TAKEN_ON_BIT0: assert (pin_out[0] == taken); // R1
  end

endmodule

// File: tb/branch_cond_eval_tb.sv
module branch_cond_eval_tb;

  typedef struct {
    logic [3:0] a;
    logic [3:0] b;
    logic [2:0] code;
    logic       exp_taken;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic [7:0] pin_in = '0;
  logic [2:0] pio_in = '0;
  logic [7:0] pin_out, pio_out, pio_oe;

  int unsigned n_tests = 0;
  int unsigned n_fail  = 0;
  int unsigned cycles  = 0;
  bit          done    = 1'b0;
  item_t       sb_q[$];

  always #10 clk = ~clk; // 50 MHz

  branch_cond_eval u_dut (
    .pin_in  (pin_in),
    .pio_in  (pio_in),
    .pin_out (pin_out),
    .pio_out (pio_out),
    .pio_oe  (pio_oe)
  );

  // Reference model: signed order via flipping the sign bit, no signed arithmetic
  function automatic logic ref_taken(input logic [3:0] a, input logic [3:0] b, input logic [2:0] c);
    logic [3:0] as = a ^ 4'h8;
    logic [3:0] bs = b ^ 4'h8;
    case (c)
      3'd0: return a == b;
      3'd1: return a != b;
      3'd2: return as < bs;
      3'd3: return as >= bs;
      3'd4: return a < b;
      3'd5: return a >= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4, 3'd5: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic drive(input logic [3:0] a, input logic [3:0] b, input logic [2:0] c,
                       input logic exp, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    pin_in = {a, b}; // R1 packing
    pio_in = c;
    it.a = a; it.b = b; it.code = c; it.exp_taken = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare at the falling edge, before any further rising edge (R9)
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (pin_out[0] !== it.exp_taken) begin
        n_fail++;
        $display("FAIL %s: A=%h B=%h code=%0d taken actual=%b expected=%b",
                 it.tag, it.a, it.b, it.code, pin_out[0], it.exp_taken);
      end
      n_tests++;
      if (pin_out[7:1] !== 7'd0 || pio_out !== 8'd0 || pio_oe !== 8'd0) begin
        n_fail++;
        $display("FAIL R8: upper=%h pio_out=%h pio_oe=%h expected all 0",
                 pin_out[7:1], pio_out, pio_oe);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // Idle state with all inputs zero: equal operands under code 0
    #5;
    n_tests++;
    if (pin_out !== 8'h01 || pio_oe !== 8'h00) begin
      n_fail++;
      $display("FAIL R8: idle pin_out=%h pio_oe=%h expected 01/00", pin_out, pio_oe);
    end

    // Directed cases from the requirements
    drive(4'h5, 4'h5, 3'd0, 1'b1, "R2");
    drive(4'h5, 4'h3, 3'd1, 1'b1, "R3");
    drive(4'h3, 4'h5, 3'd2, 1'b1, "R4");
    drive(4'h8, 4'h7, 3'd2, 1'b1, "R4");
    drive(4'h5, 4'h5, 3'd3, 1'b1, "R4");
    drive(4'h3, 4'h5, 3'd4, 1'b1, "R5");
    drive(4'h5, 4'h3, 3'd5, ref_taken(4'h5, 4'h3, 3'd5), "R5");
    drive(4'hF, 4'h1, 3'd2, 1'b1, "R6");
    drive(4'hF, 4'h1, 3'd4, 1'b0, "R6");
    drive(4'h3, 4'h3, 3'd6, 1'b0, "R7");
    drive(4'h0, 4'hF, 3'd7, 1'b0, "R7");
    drive(4'hA, 4'h0, 3'd0, 1'b0, "R1");
    drive(4'h0, 4'hA, 3'd5, 1'b0, "R1");

    // Full sweep: every pair under every code, one per cycle (R9)
    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          drive(4'(a), 4'(b), 3'(c), ref_taken(4'(a), 4'(b), 3'(c)), tag_of(3'(c)));

    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule